// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when a 16-bit timer/counter may advance. A 3-bit select input picks one of eight sources. One code stops counting. One passes every system clock. Four take fixed divisions from a shared free-running prescaler. Two count edges on an external pin: one code counts falling edges and the other counts rising edges. The result is a single-cycle count-enable strobe in the system clock domain. The timer samples this strobe as a synchronous enable, so no derived clock is ever generated.

The external pin is sampled through a two-flop synchronizer and then compared with its previous synchronized value. The pin is only ever observed. Any toggling of the pin therefore produces counts, including toggling that the chip itself drives when the pin is used as an output. This gives software a way to step the timer.

Top module: `tick_source`

## Requirements
- R1: While `rstN` is low, `countEn` is 0. The prescaler and the pin synchronizer flops reset to 0, and the prescaler count starts at 0 on the first clock after reset is released.
- R2: With `clkSel` = 3'b000, `countEn` stays 0.
- R3: With `clkSel` = 3'b001, `countEn` is 1 on every cycle, starting one clock after the code is applied.
- R4: Codes 3'b010, 3'b011, 3'b100 and 3'b101 divide by 8, 64, 256 and 1024 respectively. The strobe fires one clock after a cycle in which the low 3, 6, 8 or 10 prescaler bits are all zero. Any 1024 consecutive cycles therefore hold exactly 128, 16, 4 or 1 pulses.
- R5: The prescaler runs freely whatever the select code is. Changing the code never restarts its phase.
- R6: With `clkSel` = 3'b110, each falling edge on `extPin` yields exactly one `countEn` pulse. The pulse appears after the third rising clock edge following the pin change.
- R7: With `clkSel` = 3'b111, each rising edge on `extPin` yields exactly one `countEn` pulse, with the same latency as R6.
- R8: `countEn` is one cycle wide for each event. Under codes 3'b000 to 3'b101, activity on `extPin` has no effect on `countEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Count source select code |
| extPin | input | 1 | Raw level of the external count pin |
| countEn | output | 1 | Single-cycle count-enable strobe |

## Verification
Each divider code is held for a full 1024-cycle window while `extPin` wiggles with random hold lengths. This confirms that every division yields its exact pulse count and that the pin is ignored. A stretch that switches codes every few dozen cycles without a reset shows whether the prescaler phase survives a code change, as opposed to restarting. The two edge codes are driven with random wiggles that include one-cycle pin pulses, and then with a regular square wave of known edge count. Because the pin starts and ends low, the number of falling edges equals the number of rising edges, so the two codes must give matching counts. A polarity swap or a doubled pulse shows up as a wrong count.

// File: rtl/tick_source_pkg.sv
package tick_source_pkg;

  typedef enum logic [2:0] {
    SEL_STOP     = 3'd0,
    SEL_DIV1     = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } tickSel_e;

  localparam int NUM_TAPS = 4;
  // Number of low prescaler bits that must be zero for each divided tap.
  localparam int TAP_SHIFT [NUM_TAPS] = '{3, 6, 8, 10};
  localparam int PRESCALE_W = TAP_SHIFT[NUM_TAPS-1];

  typedef struct packed {
    logic [NUM_TAPS-1:0] tapHit;
    logic                pinRise;
    logic                pinFall;
  } tickStrobes_t;

endpackage

// File: rtl/tick_source_dp.sv
module tick_source_dp
  import tick_source_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         extPin,
  output tickStrobes_t strobes
);

  logic [PRESCALE_W-1:0]  preCnt;
  logic [NUM_TAPS-1:0]    tapHit;
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   pinLast;
  logic                   pinNow;

  // Free-running prescaler shared by all divided taps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int SH = TAP_SHIFT[k];
    assign tapHit[k] = (preCnt[SH-1:0] == '0);
  end

  // Pin synchronizer followed by one history flop for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      pinLast  <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], extPin};
      pinLast  <= syncPipe[SYNC_STAGES-1];
    end
  end

  assign pinNow = syncPipe[SYNC_STAGES-1];

  assign strobes.tapHit  = tapHit;
  assign strobes.pinRise = pinNow & ~pinLast;
  assign strobes.pinFall = ~pinNow & pinLast;

endmodule

// File: rtl/tick_source_ctl.sv
module tick_source_ctl
  import tick_source_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   clkSel,
  input  tickStrobes_t strobes,
  output logic         countEn
);

  tickSel_e selCode;
  logic     pick;

  assign selCode = tickSel_e'(clkSel);

  always_comb begin
    case (selCode)
      SEL_STOP:     pick = 1'b0;
      SEL_DIV1:     pick = 1'b1;
      SEL_DIV8:     pick = strobes.tapHit[0];
      SEL_DIV64:    pick = strobes.tapHit[1];
      SEL_DIV256:   pick = strobes.tapHit[2];
      SEL_DIV1024:  pick = strobes.tapHit[3];
      SEL_EXT_FALL: pick = strobes.pinFall;
      SEL_EXT_RISE: pick = strobes.pinRise;
      default:      pick = 1'b0;
    endcase
  end

  // Registered so the strobe is glitch-free and exactly one clock wide.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countEn <= 1'b0;
    else       countEn <= pick;
  end

endmodule

// File: rtl/tick_source.sv
module tick_source
  import tick_source_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] clkSel,
  input  logic       extPin,
  output logic       countEn
);

  tickStrobes_t strobes;

  tick_source_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .extPin  (extPin),
    .strobes (strobes)
  );

  tick_source_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .clkSel  (clkSel),
    .strobes (strobes),
    .countEn (countEn)
  );

endmodule

// File: rtl/tick_source_chk.sv
module tick_source_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] clkSel,
  input logic       extPin,
  input logic       countEn
);

  always_comb begin
    if (!rstN) assert_reset_quiet_R1: assert (countEn == 1'b0);
  end

  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clkSel) == 3'd0) |-> !countEn);

  assert_full_rate_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkSel) == 3'd1) |-> countEn);

  assert_div_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel >= 3'd2 && clkSel <= 3'd5 && $past(clkSel) == clkSel && countEn) |=> !countEn);

  assert_fall_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 4) && $past(clkSel) == 3'd6 && countEn) |-> (!$past(extPin, 3) && $past(extPin, 4)));

  assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 4) && $past(clkSel) == 3'd7 && countEn) |-> ($past(extPin, 3) && !$past(extPin, 4)));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel >= 3'd6 && $past(clkSel) == clkSel && countEn) |=> !countEn);

endmodule

bind tick_source tick_source_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .clkSel  (clkSel),
  .extPin  (extPin),
  .countEn (countEn)
);

// File: tb/tick_source_bench.sv
`timescale 1ns/1ps
module tick_source_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] clkSel = 3'd0;
  logic       extPin = 1'b0;
  logic       countEn;

  int    compared = 0;
  int    mismatched = 0;
  bit    cmpOn = 1'b0;
  bit    done = 1'b0;
  string phaseTag = "R1";

  // Behavioural reference state
  int  tick = 0;
  bit  hist[$];
  bit  expEn = 1'b0;

  int  pulses = 0;
  int  holdLeft = 0;
  int  lfsr = 32'h1ACE5;

  always #4 clk = ~clk;

  tick_source u_tick_source (
    .clk     (clk),
    .rstN    (rstN),
    .clkSel  (clkSel),
    .extPin  (extPin),
    .countEn (countEn)
  );

  // Reference model: prescale phase as an integer, pin samples as a queue.
  always @(posedge clk) begin
    if (!rstN) begin
      tick  = 0;
      hist  = '{1'b0, 1'b0, 1'b0};
      expEn = 1'b0;
    end else begin
      case (clkSel)
        3'd0: expEn = 1'b0;
        3'd1: expEn = 1'b1;
        3'd2: expEn = (tick % 8) == 0;
        3'd3: expEn = (tick % 64) == 0;
        3'd4: expEn = (tick % 256) == 0;
        3'd5: expEn = (tick % 1024) == 0;
        3'd6: expEn = !hist[1] && hist[0];
        default: expEn = hist[1] && !hist[0];
      endcase
      tick = (tick + 1) % 1024;
      hist.push_back(extPin);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      compared++;
      if (countEn !== expEn) begin
        mismatched++;
        $display("FAIL %s: countEn=%b expected %b (sel=%0d) at %0t",
                 phaseTag, countEn, expEn, clkSel, $time);
      end
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, actual, expected);
    end
  endtask

  // One cycle: count strobes, optionally move the pin with random holds.
  task automatic step(input bit wiggle);
    @(negedge clk);
    if (countEn === 1'b1) pulses++;
    if (wiggle) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      if (holdLeft == 0) begin
        extPin   = ~extPin;
        holdLeft = lfsr & 3;
      end else begin
        holdLeft--;
      end
    end
  endtask

  task automatic steps(input int n, input bit wiggle);
    for (int i = 0; i < n; i++) step(wiggle);
  endtask

  task automatic squareCount(input logic [2:0] code, input string tag);
    clkSel = code;
    extPin = 1'b0;
    steps(8, 1'b0);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      extPin = 1'b1;
      steps(5, 1'b0);
      extPin = 1'b0;
      steps(5, 1'b0);
    end
    steps(6, 1'b0);
    check(tag, pulses, 20);
  endtask

  initial begin
    int divs [6] = '{0, 1024, 128, 16, 4, 1};
    string tags [6] = '{"R2/R8", "R3/R8", "R4/R8", "R4/R8", "R4/R8", "R4/R8"};
    repeat (3) @(negedge clk);
    cmpOn = 1'b1;
    check("R1 reset", int'(countEn), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first cycle", int'(countEn), 0);

    // Each internal code over a full 1024-cycle window, pin wiggling.
    for (int c = 0; c < 6; c++) begin
      phaseTag = tags[c];
      clkSel = 3'(c);
      steps(4, 1'b1);
      pulses = 0;
      steps(1024, 1'b1);
      check(tags[c], pulses, divs[c]);
    end

    // R5: rapid code changes without reset; model keeps its own phase.
    phaseTag = "R5";
    for (int i = 0; i < 24; i++) begin
      clkSel = 3'(2 + (i % 4));
      steps(37, 1'b0);
    end

    // R6 / R7: random pin activity including one-cycle pulses.
    phaseTag = "R6";
    clkSel = 3'd6;
    steps(1500, 1'b1);
    phaseTag = "R7";
    clkSel = 3'd7;
    steps(1500, 1'b1);

    phaseTag = "R6";
    squareCount(3'd6, "R6 fall count");
    phaseTag = "R7";
    squareCount(3'd7, "R7 rise count");

    phaseTag = "R2";
    clkSel = 3'd0;
    steps(4, 1'b0);
    check("R2 stop final", int'(countEn), 0);

    cmpOn = 1'b0;
    done  = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule